// File: doc/BRIEF.md
# Audio Control Register Slave (Write-Only Two-Wire Bus)

This block receives control settings for a three-channel audio processor over a two-wire serial bus (I2C, write direction only) and holds them in six internal control registers whose fields are brought out as decoded outputs. The bus lines are oversampled by a fast system clock. Each of SCL and SDA passes through a two-flop synchroniser before start, stop and clock edges are detected. Acknowledge bits are returned through an open-drain enable that pulls SDA low.

A transfer consists of a start condition, the device address byte, a sub-address byte, and then any number of data bytes, and ends with a stop or a repeated start. Bit 7 of the sub-address selects the pointer mode. When it is 0, the register pointer steps forward after every data byte. When it is 1, every data byte rewrites the same register, so the last byte written wins. Bits 3:0 of the sub-address load the pointer. The outputs are three channel volumes, three tone and effect levels, six on/off switches, a centre source select and an extension output bit.

Top module: `audio_ctl_i2c`

## Requirements
- R1: After reset, every output field is zero and `sda_oe` is low.
- R2: Only the address byte 0x80 (7-bit address 0x40, write) is acknowledged. Any other address byte, including 0x81, gets no acknowledge. Every later byte is also left without acknowledge and without effect, until the next start condition.
- R3: For each accepted byte (the address, the sub-address, each data byte), `sda_oe` is high while SCL is high during the ninth clock. It is low again once SCL falls after that clock, and it only rises while SCL is low.
- R4: A sub-address with bit 7 = 0 loads the pointer from bits 3:0. After each data byte the pointer advances by one, modulo 16.
- R5: A sub-address with bit 7 = 1 loads the pointer from bits 3:0 and keeps it fixed, so every data byte rewrites the same register.
- R6: Registers 0 to 2 hold the volume fields in bits 5:0: left in register 0, right in register 1, centre in register 2. The switch flags they carry are AGC in register 0 bit 7, mute in register 1 bit 7, centre mute in register 2 bit 7, and surround in register 2 bit 6.
- R7: Register 3 holds treble in bits 3:0 and bass mix in bit 7. Register 4 holds the surround level in bits 3:0 and the centre source select in bit 7, where 1 selects the external input. Register 5 holds bass in bits 3:0, surround loop in bit 7 and the extension output in bit 6. Bits not named are discarded.
- R8: A data byte aimed at a pointer value from 6 to 15 is acknowledged, but it changes no output. No output changes except through a data byte accepted for registers 0 to 5.
- R9: A stop condition ends the transfer and releases `sda_oe`. A start condition, including a repeated start without a stop, restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| vol_left | output | VOL_W | Left volume, 0 = minimum |
| vol_right | output | VOL_W | Right volume |
| vol_center | output | VOL_W | Centre volume |
| treble_lvl | output | LVL_W | Treble level, all channels |
| bass_lvl | output | LVL_W | Bass level, all channels |
| surr_lvl | output | LVL_W | Surround effect level |
| agc_on | output | 1 | Automatic gain control enable |
| mute_on | output | 1 | Left/right mute |
| cmute_on | output | 1 | Centre mute |
| surr_on | output | 1 | Surround enable |
| bmix_on | output | 1 | Bass mix enable |
| loop_on | output | 1 | Surround loop enable |
| csrc_ext | output | 1 | Centre source: 0 internal sum, 1 external input |
| ext_out | output | 1 | Extension output level |

## Verification
The hardest situations to reach from the ports are pointer edges. One is an auto-increment burst that runs past register 5 and then wraps from 15 back to register 0. The other is a repeated start that arrives in the middle of a data phase, with no stop in between. Directed transfers start at sub-address 0x04 and 0x0F with bursts long enough to cross these edges, and one transfer is cut off by a repeated start. Random transfers then mix the two modes, starting pointers from 0 to 15, burst lengths and the occasional wrong address. After each stop, every output is compared with a bench model of the six registers.

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int VOL_W = 6,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [VOL_W-1:0] vol_left,
  output logic [VOL_W-1:0] vol_right,
  output logic [VOL_W-1:0] vol_center,
  output logic [LVL_W-1:0] treble_lvl,
  output logic [LVL_W-1:0] bass_lvl,
  output logic [LVL_W-1:0] surr_lvl,
  output logic             agc_on,
  output logic             mute_on,
  output logic             cmute_on,
  output logic             surr_on,
  output logic             bmix_on,
  output logic             loop_on,
  output logic             csrc_ext,
  output logic             ext_out
);
  localparam int          NREG     = 6;
  localparam logic [7:0]  ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int          FLD_W    = 3*VOL_W + 3*LVL_W + 8;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA, PH_SKIP} phase_t;

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  wire scl_rise  =  scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] &  scl_q[2];
  wire start_det =  scl_q[1] & scl_q[2] &  sda_q[2] & ~sda_q[1];
  wire stop_det  =  scl_q[1] & scl_q[2] & ~sda_q[2] &  sda_q[1];

  phase_t     phase;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [3:0] ptr;
  logic       renew;
  logic       oe_q;

  wire byte_done = scl_fall && (bit_cnt == 4'd8);
  wire wr_en     = byte_done && (phase == PH_DATA);
  wire active    = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      renew   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'd8) begin
        shreg   <= {shreg[6:0], sda_q[1]};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (byte_done) begin
        bit_cnt <= 4'd9;
        case (phase)
          PH_ADDR: if (shreg == ADDR_BYTE) oe_q <= 1'b1;
                   else phase <= PH_SKIP;
          PH_SUB: begin
            ptr   <= shreg[3:0];
            renew <= shreg[7];
            oe_q  <= 1'b1;
          end
          default: begin
            oe_q <= 1'b1;
            if (!renew) ptr <= ptr + 4'd1;
          end
        endcase
      end else if (scl_fall && bit_cnt == 4'd9) begin
        oe_q    <= 1'b0;
        bit_cnt <= '0;
        if (phase == PH_ADDR)     phase <= PH_SUB;
        else if (phase == PH_SUB) phase <= PH_DATA;
      end
    end
  end

  assign sda_oe = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_left <= '0; vol_right <= '0; vol_center <= '0;
      treble_lvl <= '0; bass_lvl <= '0; surr_lvl <= '0;
      agc_on <= 1'b0; mute_on <= 1'b0; cmute_on <= 1'b0; surr_on <= 1'b0;
      bmix_on <= 1'b0; loop_on <= 1'b0; csrc_ext <= 1'b0; ext_out <= 1'b0;
    end else if (wr_en && ptr < 4'(NREG)) begin
      case (ptr)
        4'd0: begin vol_left   <= shreg[VOL_W-1:0]; agc_on  <= shreg[7]; end
        4'd1: begin vol_right  <= shreg[VOL_W-1:0]; mute_on <= shreg[7]; end
        4'd2: begin
          vol_center <= shreg[VOL_W-1:0];
          cmute_on   <= shreg[7];
          surr_on    <= shreg[6];
        end
        4'd3: begin treble_lvl <= shreg[LVL_W-1:0]; bmix_on  <= shreg[7]; end
        4'd4: begin surr_lvl   <= shreg[LVL_W-1:0]; csrc_ext <= shreg[7]; end
        default: begin
          bass_lvl <= shreg[LVL_W-1:0];
          loop_on  <= shreg[7];
          ext_out  <= shreg[6];
        end
      endcase
    end
  end

  wire [FLD_W-1:0] fields = {vol_left, vol_right, vol_center, treble_lvl, bass_lvl,
                             surr_lvl, agc_on, mute_on, cmute_on, surr_on, bmix_on,
                             loop_on, csrc_ext, ext_out};

  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_q[1]);

  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !oe_q);

  assert_auto_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !renew && !start_det && !stop_det) |=> ptr == $past(ptr) + 4'd1);

  assert_renew_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && renew) |=> $stable(ptr));

  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ptr < 4'(NREG)) |=> $stable(fields));

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe_q && phase == PH_IDLE));
endmodule

// File: tb/audio_ctl_i2c_tb.sv
module audio_ctl_i2c_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  logic [5:0] vol_left, vol_right, vol_center;
  logic [3:0] treble_lvl, bass_lvl, surr_lvl;
  logic agc_on, mute_on, cmute_on, surr_on, bmix_on, loop_on, csrc_ext, ext_out;

  always #2 clk = ~clk;

  audio_ctl_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .vol_left(vol_left), .vol_right(vol_right), .vol_center(vol_center),
    .treble_lvl(treble_lvl), .bass_lvl(bass_lvl), .surr_lvl(surr_lvl),
    .agc_on(agc_on), .mute_on(mute_on), .cmute_on(cmute_on), .surr_on(surr_on),
    .bmix_on(bmix_on), .loop_on(loop_on), .csrc_ext(csrc_ext), .ext_out(ext_out));

  int tests = 0;
  int fails = 0;
  logic [7:0] model [6];
  logic [7:0] buf_d [8];

  function automatic logic [37:0] expect_vec();
    return {model[0][5:0], model[1][5:0], model[2][5:0], model[3][3:0], model[5][3:0],
            model[4][3:0], model[0][7], model[1][7], model[2][7], model[2][6],
            model[3][7], model[5][7], model[4][7], model[5][6]};
  endfunction

  function automatic logic [37:0] actual_vec();
    return {vol_left, vol_right, vol_center, treble_lvl, bass_lvl, surr_lvl, agc_on,
            mute_on, cmute_on, surr_on, bmix_on, loop_on, csrc_ext, ext_out};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q/2);
    ack = ~sda_line;
    wq(Q/2); scl = 1'b0; wq(Q);
    check("R3 sda_oe released after ack clock", 64'(sda_oe), 64'd0);
  endtask

  task automatic xfer(input logic [7:0] addr, input logic [7:0] sub, input int n,
                      input bit do_stop);
    logic ack;
    logic [3:0] p;
    bit ok;
    ok = (addr == 8'h80);
    i2c_start();
    send_byte(addr, ack);
    check("R2 address acknowledge", 64'(ack), 64'(ok));
    send_byte(sub, ack);
    check("R2 sub-address acknowledge", 64'(ack), 64'(ok));
    p = sub[3:0];
    for (int k = 0; k < n; k++) begin
      send_byte(buf_d[k], ack);
      check("R8 data acknowledge", 64'(ack), 64'(ok));
      if (ok) begin
        if (p < 4'd6) model[p] = buf_d[k];
        if (!sub[7]) p = p + 4'd1;
      end
    end
    if (do_stop) begin
      i2c_stop();
      wq(4);
      check("R6 R7 fields after transfer", 64'(actual_vec()), 64'(expect_vec()));
      check("R9 released after stop", 64'(sda_oe), 64'd0);
    end
  endtask

  initial begin
    #(180000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5173));
    for (int i = 0; i < 6; i++) model[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(5);
    check("R1 reset fields", 64'(actual_vec()), 64'd0);
    check("R1 reset sda_oe", 64'(sda_oe), 64'd0);

    for (int k = 0; k < 6; k++) buf_d[k] = 8'hFF - 8'(k * 17);
    xfer(8'h80, 8'h00, 6, 1'b1);
    check("R4 auto-increment burst left volume", 64'(vol_left), 64'h3F);
    check("R6 AGC flag from register 0 bit 7", 64'(agc_on), 64'd1);

    buf_d[0] = 8'h15; buf_d[1] = 8'h7A; buf_d[2] = 8'h41;
    xfer(8'h80, 8'h82, 3, 1'b1);
    check("R5 renewal keeps last byte", 64'(vol_center), 64'h01);
    check("R5 renewal leaves register 3", 64'(treble_lvl), 64'(model[3][3:0]));

    buf_d[0] = 8'h8C; buf_d[1] = 8'hC3; buf_d[2] = 8'hFF; buf_d[3] = 8'hFF;
    xfer(8'h80, 8'h04, 4, 1'b1);
    check("R7 extension output", 64'(ext_out), 64'd1);
    check("R7 centre source external", 64'(csrc_ext), 64'd1);

    buf_d[0] = 8'h00; buf_d[1] = 8'h2A;
    xfer(8'h80, 8'h0F, 2, 1'b1);
    check("R4 pointer wraps 15 to 0", 64'(vol_left), 64'h2A);

    buf_d[0] = 8'h00;
    xfer(8'h82, 8'h00, 1, 1'b1);
    check("R2 wrong address ignored", 64'(vol_left), 64'h2A);
    xfer(8'h81, 8'h01, 1, 1'b1);

    buf_d[0] = 8'h33; buf_d[1] = 8'h05;
    xfer(8'h80, 8'h01, 1, 1'b0);
    xfer(8'h80, 8'h03, 2, 1'b1);
    check("R9 repeated start restarts", 64'(vol_right), 64'h33);

    for (int t = 0; t < 30; t++) begin
      logic [7:0] a, s;
      int n;
      a = ($urandom_range(0, 9) == 0) ? 8'(($urandom_range(0, 127) << 1) | 1) : 8'h80;
      s = {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 3'b000, 4'($urandom_range(0, 15))};
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) buf_d[k] = 8'($urandom());
      xfer(a, s, n, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule